// File: doc/BRIEF.md
# Byte-Write Configuration Peripheral Port

This block lets a host processor push configuration bytes into a chip over a small byte bus. The host selects the port with two chip selects, one active low and one active high, and presents a byte on the data bus while it pulses the active-low write strobe. Each accepted byte lands in a hold register. As soon as the shift register behind it is empty, the byte moves on and is sent out bit-serially on a generated serial clock, one bit per serial clock period. An oscillator outside the block supplies a one-cycle tick, and that tick paces the serial clock.

The ready flag is the block's back-pressure. While it is high, a write strobe is taken. While it is low, the hold register is occupied and a write is dropped. A dropped write sets a sticky overrun flag. The host can watch the ready pin, or it can read the flag back over the upper five data pins by selecting the port with the write strobe high and the read strobe low. The three low data pins are inputs only.

Top module: `cfg_byte_port`

## Requirements
- R1: A write is accepted only on a clock edge where `cs_n` is 0, `cs_act` is 1, and `wr_n` is sampled low after being sampled high on the edge before. A falling `wr_n` with either select inactive changes nothing: no serial pulses, `rdy` stays 1 and `ovr` stays 0. The selects may stay asserted for a whole load or be dropped between writes.
- R2: After an accepted write, `rdy` reads 0 from the next cycle and stays 0 until the hold register hands its byte to the shift register.
- R3: When the shift register is idle at the write, the hand-over happens on the following clock, so `rdy` is 0 for exactly one cycle.
- R4: When a byte is written just after the shift register has been loaded, `rdy` stays 0 until all eight serial clock pulses of the byte already shifting have been produced.
- R5: Each accepted byte produces exactly eight rising edges of `ser_clk`. `ser_clk` changes only on a cycle after `osc_en` was 1. Each bit spends one tick with `ser_clk` low and one tick with it high.
- R6: Bits leave least significant bit first. `ser_dat` holds the current bit and is stable across each rising edge of `ser_clk`.
- R7: A write accepted by R1's strobe rule while `rdy` is 0 is dropped: its byte never appears on `ser_dat`. It sets `ovr` to 1, and `ovr` stays 1 until the synchronous reset `rst`.
- R8: `stat_oe` is 1 exactly when `cs_n`=0, `cs_act`=1, `wr_n`=1 and `rd_n`=0. While `stat_oe` is 1, every bit of `stat_q` (data pins 7..3) equals `rdy`. Data pins 2..0 have no output path.
- R9: After reset, `rdy`=1, `ovr`=0, `ser_clk`=0 and `ser_dat`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | Oscillator tick, one cycle wide, paces the serial clock |
| cs_n | input | 1 | Chip select, active low |
| cs_act | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Status read strobe, active low |
| din | input | DW (8) | Byte from the host data bus |
| ser_dat | output | 1 | Serial configuration data |
| ser_clk | output | 1 | Generated serial clock |
| rdy | output | 1 | High when the hold register can take a byte |
| ovr | output | 1 | Sticky flag for a write dropped while busy |
| stat_oe | output | 1 | Output enable for the upper data pins |
| stat_q | output | DW-3 (5) | Status value for data pins 7..3 |

## Verification
The assertions check the rules that hold on every cycle. The overrun flag never drops outside reset and only rises while the port is busy. The serial clock moves only after an oscillator tick. Data is steady at each rising serial edge. An accepted write drops `rdy` on the next cycle. The status pins mirror `rdy` whenever they are enabled. The bench scenarios cover what needs a whole history: the exact bit order and byte count on the serial line against a scoreboard, the one-cycle versus eight-pulse busy time, that deselected or overrunning writes never reach the serial stream, and that only reset clears the overrun flag.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  // Serial clock phase: a bit is set up while low and sampled on the rise.
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} sclk_ph_t;
endpackage

// File: rtl/cfg_strobe.sv
module cfg_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic cs_act,
  input  logic wr_n,
  input  logic rd_n,
  output logic wr_go,
  output logic rd_en
);
  logic wr_n_q;
  logic sel;

  assign sel   = ~cs_n & cs_act;
  assign wr_go = sel & ~wr_n & wr_n_q;
  assign rd_en = sel & wr_n & ~rd_n;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n;
  end
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  logic [DW-1:0] din,
  input  logic          xfer,
  output logic          hold_v,
  output logic [DW-1:0] hold_d,
  output logic          ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      ovr    <= 1'b0;
    end else begin
      if (xfer) hold_v <= 1'b0;
      if (wr_go) begin
        if (!hold_v) begin
          hold_v <= 1'b1;
          hold_d <= din;
        end else begin
          ovr <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic          load,
  input  logic [DW-1:0] load_d,
  output logic          idle,
  output logic          ser_dat,
  output logic          ser_clk
);
  import cfg_pkg::*;
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sreg;
  logic          busy;
  logic [CW-1:0] bitn;
  sclk_ph_t      ph;

  assign idle    = ~busy;
  assign ser_dat = sreg[0];
  assign ser_clk = (ph == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      busy <= 1'b0;
      bitn <= '0;
      ph   <= PH_LOW;
    end else if (load && !busy) begin
      sreg <= load_d;
      busy <= 1'b1;
      bitn <= '0;
      ph   <= PH_LOW;
    end else if (busy && osc_en) begin
      if (ph == PH_LOW) begin
        ph <= PH_HIGH;
      end else begin
        ph   <= PH_LOW;
        sreg <= sreg >> 1;
        if (bitn == LAST) begin
          busy <= 1'b0;
          bitn <= '0;
        end else begin
          bitn <= bitn + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
  parameter int DW       = 8,
  parameter int STAT_LSB = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   osc_en,
  input  logic                   cs_n,
  input  logic                   cs_act,
  input  logic                   wr_n,
  input  logic                   rd_n,
  input  logic [DW-1:0]          din,
  output logic                   ser_dat,
  output logic                   ser_clk,
  output logic                   rdy,
  output logic                   ovr,
  output logic                   stat_oe,
  output logic [DW-STAT_LSB-1:0] stat_q
);
  localparam int SW = DW - STAT_LSB;

  logic          wr_go;
  logic          rd_en;
  logic          hold_v;
  logic [DW-1:0] hold_d;
  logic          sh_idle;
  logic          xfer;

  cfg_strobe u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs_act(cs_act),
    .wr_n(wr_n), .rd_n(rd_n), .wr_go(wr_go), .rd_en(rd_en)
  );

  assign xfer = hold_v & sh_idle;

  cfg_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .wr_go(wr_go), .din(din), .xfer(xfer),
    .hold_v(hold_v), .hold_d(hold_d), .ovr(ovr)
  );

  cfg_serializer #(.DW(DW)) u_ser (
    .clk(clk), .rst(rst), .osc_en(osc_en), .load(xfer), .load_d(hold_d),
    .idle(sh_idle), .ser_dat(ser_dat), .ser_clk(ser_clk)
  );

  assign rdy     = ~hold_v;
  assign stat_oe = rd_en;
  assign stat_q  = {SW{rdy}};
endmodule

// File: rtl/cfg_byte_port_chk.sv
module cfg_byte_port_chk #(
  parameter int DW       = 8,
  parameter int STAT_LSB = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   osc_en,
  input logic                   cs_n,
  input logic                   cs_act,
  input logic                   wr_n,
  input logic                   rd_n,
  input logic [DW-1:0]          din,
  input logic                   ser_dat,
  input logic                   ser_clk,
  input logic                   rdy,
  input logic                   ovr,
  input logic                   stat_oe,
  input logic [DW-STAT_LSB-1:0] stat_q
);
  localparam int SW = DW - STAT_LSB;

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr);

  a_r7_ovr_rise_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(!rdy));

  a_r5_clk_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_clk) |-> $past(osc_en));

  a_r6_dat_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_dat));

  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    ($fell(wr_n) && !cs_n && cs_act && rdy) |=> !rdy);

  a_r8_status_mirror: assert property (@(posedge clk) disable iff (rst)
    stat_oe |-> (stat_q == {SW{rdy}}));
endmodule

bind cfg_byte_port cfg_byte_port_chk #(.DW(DW), .STAT_LSB(STAT_LSB)) u_chk (.*);

// File: tb/cfg_byte_port_tb_top.sv
module cfg_byte_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b0;
  logic       cs_n = 1'b1;
  logic       cs_act = 1'b0;
  logic       wr_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] din = '0;
  logic       ser_dat, ser_clk, rdy, ovr, stat_oe;
  logic [4:0] stat_q;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  int accepted = 0;
  logic [7:0] exp_q[$];
  logic [7:0] shreg;
  int  nbit = 0;
  logic sclk_d = 1'b0;

  cfg_byte_port dut_i (
    .clk(clk), .rst(rst), .osc_en(osc_en), .cs_n(cs_n), .cs_act(cs_act),
    .wr_n(wr_n), .rd_n(rd_n), .din(din), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .rdy(rdy), .ovr(ovr), .stat_oe(stat_oe), .stat_q(stat_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) osc_en = ~osc_en;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: collect bits on each serial rising edge, compare whole bytes.
  always @(negedge clk) begin
    if (rst) begin
      nbit = 0;
      sclk_d = 1'b0;
    end else begin
      if (ser_clk && !sclk_d) begin
        rises++;
        shreg[nbit] = ser_dat;
        nbit++;
        if (nbit == 8) begin
          nbit = 0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected byte", int'(shreg), -1);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(shreg == e, "R6 serial byte", int'(shreg), int'(e));
          end
        end
      end
      sclk_d = ser_clk;
    end
  end

  // Driver: called on a negedge; leaves on the next negedge with wr_n high.
  task automatic wr_byte(input logic [7:0] b, input logic sel_on);
    cs_n   = ~sel_on;
    cs_act = sel_on;
    din    = b;
    if (sel_on && rdy) begin
      exp_q.push_back(b);
      accepted++;
    end
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (rdy && exp_q.size() == 0 && rises == 8*accepted) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYCLES);
    finish_run();
  end

  initial begin
    int r0;
    int busy;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(rdy == 1'b1, "R9 rdy", rdy, 1);
    chk(ovr == 1'b0, "R9 ovr", ovr, 0);
    chk(ser_clk == 1'b0, "R9 ser_clk", ser_clk, 0);
    chk(ser_dat == 1'b0, "R9 ser_dat", ser_dat, 0);

    // R1: deselected writes do nothing
    r0 = rises;
    wr_byte(8'hA5, 1'b0);
    cs_n = 1'b0; cs_act = 1'b0; wr_n = 1'b0; @(negedge clk); wr_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(rises == r0, "R1 no pulses when deselected", rises - r0, 0);
    chk(rdy == 1'b1, "R1 rdy after deselected write", rdy, 1);
    chk(ovr == 1'b0, "R1 ovr after deselected write", ovr, 0);

    // R8: status read while idle and while deselected
    cs_n = 1'b0; cs_act = 1'b1; rd_n = 1'b0;
    #1;
    chk(stat_oe == 1'b1, "R8 oe on read", stat_oe, 1);
    chk(stat_q == 5'b11111, "R8 status ready", stat_q, 31);
    cs_act = 1'b0;
    #1;
    chk(stat_oe == 1'b0, "R8 oe off deselected", stat_oe, 0);
    rd_n = 1'b1;
    @(negedge clk);

    // R3 minimum busy, then R4 longest busy
    r0 = rises;
    wr_byte(8'h3C, 1'b1);
    chk(rdy == 1'b0, "R2 busy after write", rdy, 0);
    rd_n = 1'b0; #1;
    chk(stat_q == 5'b00000, "R8 status busy", stat_q, 0);
    rd_n = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b1, "R3 one-cycle busy", rdy, 1);
    wr_byte(8'hC1, 1'b1);
    busy = 0;
    while (!rdy && busy < 200) begin
      @(negedge clk);
      busy++;
    end
    chk(rises - r0 == 8, "R4 busy until eight pulses", rises - r0, 8);
    drain();
    chk(rises - r0 == 16, "R5 two bytes sixteen pulses", rises - r0, 16);

    // R7 overrun: third write while hold is full
    @(negedge clk);
    wr_byte(8'h81, 1'b1);
    @(negedge clk);
    wr_byte(8'h7E, 1'b1);
    @(negedge clk);
    chk(rdy == 1'b0, "R7 busy before overrun", rdy, 0);
    wr_byte(8'hFF, 1'b1);
    chk(ovr == 1'b1, "R7 ovr set", ovr, 1);
    drain();
    chk(ovr == 1'b1, "R7 ovr sticky", ovr, 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(ovr == 1'b0, "R7 ovr cleared by reset", ovr, 0);

    // Random stream with gaps, polling rdy; selects static or toggled
    for (int n = 0; n < 40; n++) begin
      while (!rdy) @(negedge clk);
      wr_byte(8'($urandom_range(0, 255)), 1'b1);
      if ($urandom_range(0, 1) == 1) begin
        cs_n = 1'b1; cs_act = 1'b0;
      end
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    drain();
    chk(exp_q.size() == 0, "R5 all bytes emitted", exp_q.size(), 0);
    chk(rises == 8*accepted, "R5 pulse total", rises, 8*accepted);
    chk(ovr == 1'b0, "R7 no overrun when polling", ovr, 0);
    finish_run();
  end
endmodule